// File: doc/BRIEF.md
# Transport Stream Energy Dispersal Randomizer

This block whitens a byte-wide transport stream before channel coding. Payload bits are combined by XOR with a pseudo-random sequence from a 15-stage shift register with feedback polynomial 1 + x^14 + x^15. The stream is handled in groups of eight 188-byte packets. At the sync byte that opens each group, the register is reloaded with a fixed seed and that sync byte is sent complemented. The sync bytes of the other seven packets leave unchanged, while the sequence keeps stepping through them. One group therefore consumes 1503 sequence bytes before the seed comes back.

An upstream packetizer marks every sync byte and flags the sync byte that should open a group. Both ports use a valid/ready handshake, and the result comes out one register stage later. The block keeps its own count of sync bytes. If no group flag arrives, it opens the next group by itself after seven further sync bytes. A group flag that arrives at any other position realigns the block at once. After reset or flush, input is consumed and discarded until a group flag is seen. Synchronous active-high reset and flush return the block to that unaligned state.

Top module: `ts_scrambler`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: An accepted byte with `in_sync` and `in_first` both high opens a group. It is output complemented (0x47 becomes 0xB8) with `out_first` and `out_sync` set. The shift register is loaded with the seed 100101010000000, which is stages 1 to 15 in that order. The register does not step on this byte.
- R3: On every other accepted payload byte, the register steps eight times. Each step forms stage14 XOR stage15, shifts that value into stage 1, and applies it to one data bit, MSB first. The first payload byte after a group start, with zero data, comes out as 0x03.
- R4: A sync byte (`in_sync` high) that does not open a group passes unchanged, with `out_sync` high and `out_first` low, and the register still steps eight times.
- R5: The register changes only on accepted bytes. Stalls on either side leave the sequence unaffected.
- R6: When aligned, the sync byte after seven non-opening sync bytes opens a new group even if `in_first` is low. The sequence period is therefore 1503 bytes, so the first payload byte of each group again reads 0x03 for zero data.
- R7: `in_first` with `in_sync` at any other position reseeds the register and restarts the group count at once.
- R8: While unaligned, accepted bytes produce no output.
- R9: While `flush` is high, `in_ready` is low. On the next cycle `out_valid` is low and the block is unaligned.
- R10: While `out_valid` is high and `out_ready` is low, the output beat holds stable and `in_ready` is low. Otherwise, outside flush, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous flush, active high |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input byte present |
| in_sync | input | 1 | Input byte is a packet sync byte |
| in_first | input | 1 | Sync byte should open a group (qualified by in_sync) |
| in_ready | output | 1 | Block can accept a byte |
| out_data | output | 8 | Randomized byte |
| out_valid | output | 1 | Output byte present |
| out_sync | output | 1 | Output byte is a sync byte |
| out_first | output | 1 | Output byte opened a group |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
A wrong register state corrupts the very next payload byte at the output, one cycle after it is accepted. A stepping error during a stall or during a pass-through sync byte shows up on the first payload byte that follows. A wrong group count appears at the ninth sync byte, which comes out unchanged instead of complemented. It can also appear one packet early as a false group start. Either way, the first payload byte of that group then differs from 0x03 when the data is zero. A lost alignment flag after flush shows as output bytes appearing before any group flag has been given.

// File: rtl/ts_scr_pkg.sv
package ts_scr_pkg;

    localparam int BYTE_W     = 8;
    localparam int LFSR_W     = 15;
    localparam int GROUP_PKTS = 8;
    // stage 1 sits in bit 0; stages 1..15 = 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0
    localparam logic [LFSR_W-1:0] SEED = 15'h00A9;

    typedef enum logic [1:0] {
        BK_DROP,
        BK_START,
        BK_SYNC,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sync;
        logic              first;
    } ts_beat_t;

    typedef struct packed {
        logic [BYTE_W-1:0] mask;
        logic [LFSR_W-1:0] next;
    } prbs_step_t;

    // Eight register steps; the first feedback bit lands in the mask MSB.
    function automatic prbs_step_t prbs_byte(input logic [LFSR_W-1:0] s);
        prbs_step_t r;
        logic [LFSR_W-1:0] st;
        logic fb;
        st     = s;
        r.mask = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb        = st[LFSR_W-2] ^ st[LFSR_W-1];
            r.mask[i] = fb;
            st        = {st[LFSR_W-2:0], fb};
        end
        r.next = st;
        return r;
    endfunction

endpackage

// File: rtl/ts_scr_align.sv
module ts_scr_align
    import ts_scr_pkg::*;
#(
    parameter int PKTS = GROUP_PKTS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       accept,
    input  logic       in_sync,
    input  logic       in_first,
    output byte_kind_e kind
);
    localparam int CNT_W = (PKTS > 1) ? $clog2(PKTS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKTS - 1);

    logic             aligned_q;
    logic [CNT_W-1:0] cnt_q;
    logic             opens;

    assign opens = in_sync & (in_first | (aligned_q & (cnt_q == LAST)));

    always_comb begin
        if (opens)           kind = BK_START;
        else if (!aligned_q) kind = BK_DROP;
        else if (in_sync)    kind = BK_SYNC;
        else                 kind = BK_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            aligned_q <= 1'b0;
            cnt_q     <= '0;
        end else if (accept) begin
            if (opens) begin
                aligned_q <= 1'b1;
                cnt_q     <= '0;
            end else if (aligned_q && in_sync) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ts_scr_prbs.sv
module ts_scr_prbs
    import ts_scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BYTE_W-1:0] mask,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] st_q;
    prbs_step_t        nxt;

    assign nxt   = prbs_byte(st_q);
    assign mask  = nxt.mask;
    assign state = st_q;

    always_ff @(posedge clk) begin
        if (rst || load) st_q <= SEED;
        else if (step)   st_q <= nxt.next;
    end
endmodule

// File: rtl/ts_scr_outreg.sv
module ts_scr_outreg
    import ts_scr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     load,
    input  ts_beat_t d,
    input  logic     out_ready,
    output logic     valid,
    output ts_beat_t q
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= d;
        end else if (out_ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ts_scrambler.sv
module ts_scrambler
    import ts_scr_pkg::*;
#(
    parameter int PKTS = GROUP_PKTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic              in_first,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sync,
    output logic              out_first,
    input  logic              out_ready
);
    byte_kind_e        kind;
    logic              accept;
    logic [BYTE_W-1:0] mask;
    logic [LFSR_W-1:0] lfsr_q;
    ts_beat_t          beat_d;
    ts_beat_t          beat_q;

    assign in_ready = !flush && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    ts_scr_align #(.PKTS(PKTS)) u_align (
        .clk(clk), .rst(rst), .flush(flush), .accept(accept),
        .in_sync(in_sync), .in_first(in_first), .kind(kind)
    );

    ts_scr_prbs u_prbs (
        .clk(clk), .rst(rst),
        .load(accept && kind == BK_START),
        .step(accept && (kind == BK_SYNC || kind == BK_DATA)),
        .mask(mask), .state(lfsr_q)
    );

    always_comb begin
        beat_d.sync  = in_sync;
        beat_d.first = (kind == BK_START);
        unique case (kind)
            BK_START: beat_d.data = ~in_data;
            BK_DATA:  beat_d.data = in_data ^ mask;
            default:  beat_d.data = in_data;
        endcase
    end

    ts_scr_outreg u_out (
        .clk(clk), .rst(rst), .flush(flush),
        .load(accept && kind != BK_DROP),
        .d(beat_d), .out_ready(out_ready),
        .valid(out_valid), .q(beat_q)
    );

    assign out_data  = beat_q.data;
    assign out_sync  = beat_q.sync;
    assign out_first = beat_q.first;
endmodule

// File: rtl/ts_scr_checker.sv
module ts_scr_checker
    import ts_scr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_sync,
    input logic              in_first,
    input logic              in_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_sync,
    input logic              out_first,
    input logic              out_ready,
    input logic [LFSR_W-1:0] lfsr_q
);
    p_start_inv_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_sync && in_first
        |=> out_valid && out_first && out_sync && out_data == ~$past(in_data));

    p_seed_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_sync && in_first |=> lfsr_q == SEED);

    p_first_is_sync_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_first |-> out_sync);

    p_sync_pass_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_sync && !in_first
        |=> !out_valid || out_first || (out_sync && out_data == $past(in_data)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(lfsr_q));

    p_flush_block_r9: assert property (@(posedge clk) disable iff (rst)
        flush |-> !in_ready);

    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst || flush)
        out_valid && !out_ready
        |=> out_valid && $stable(out_data) && $stable(out_sync) && $stable(out_first));

    p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
endmodule

bind ts_scrambler ts_scr_checker u_chk (
    .clk(clk), .rst(rst), .flush(flush),
    .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync),
    .in_first(in_first), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync),
    .out_first(out_first), .out_ready(out_ready), .lfsr_q(lfsr_q)
);

// File: tb/ts_scrambler_bench.sv
module ts_scrambler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_sync = 1'b0;
    logic       in_first = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_sync;
    logic       out_first;
    logic       out_ready = 1'b1;

    int tests = 0;
    int fails = 0;
    bit stall_mode = 1'b0;

    always #10 clk = ~clk;

    ts_scrambler u_ts_scrambler (
        .clk(clk), .rst(rst), .flush(flush),
        .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync),
        .in_first(in_first), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync),
        .out_first(out_first), .out_ready(out_ready)
    );

    // reference model state
    bit         m_st [1:15];
    bit         m_aligned;
    int         m_cnt;
    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] cap [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic m_seed();
        for (int i = 1; i <= 15; i++) m_st[i] = 1'b0;
        m_st[1] = 1; m_st[4] = 1; m_st[6] = 1; m_st[8] = 1;
    endtask

    function automatic logic [7:0] m_next_byte();
        logic [7:0] b = 8'h00;
        for (int k = 0; k < 8; k++) begin
            bit fb = m_st[14] ^ m_st[15];
            for (int i = 15; i >= 2; i--) m_st[i] = m_st[i-1];
            m_st[1] = fb;
            b = {b[6:0], fb};
        end
        return b;
    endfunction

    task automatic m_accept(input logic [7:0] d, input bit s, input bit f);
        bit opens = s && (f || (m_aligned && m_cnt == 7));
        logic [7:0] mk;
        if (opens) begin
            exp_q.push_back({~d, 1'b1, 1'b1});
            tag_q.push_back(f ? ((m_aligned && m_cnt != 7) ? "R7" : "R2") : "R6");
            m_seed();
            m_aligned = 1;
            m_cnt = 0;
        end else if (m_aligned) begin
            mk = m_next_byte();
            if (s) begin
                exp_q.push_back({d, 1'b1, 1'b0});
                tag_q.push_back("R4");
                m_cnt++;
            end else begin
                exp_q.push_back({d ^ mk, 1'b0, 1'b0});
                tag_q.push_back("R3 R5");
            end
        end
    endtask

    // monitor: compares the design against the model on every clock
    always @(negedge clk) begin
        if (rst) begin
            exp_q.delete(); tag_q.delete();
            m_aligned = 0; m_cnt = 0; m_seed();
        end else begin
            check(out_valid == (exp_q.size() > 0), "R10", "out_valid vs model",
                  out_valid, exp_q.size() > 0);
            if (out_valid && exp_q.size() > 0) begin
                check({out_data, out_sync, out_first} == exp_q[0], tag_q[0],
                      "output beat", {out_data, out_sync, out_first}, exp_q[0]);
                if (out_ready) begin
                    cap.push_back(out_data);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
            if (flush) begin
                check(!in_ready, "R9", "in_ready during flush", in_ready, 0);
                exp_q.delete(); tag_q.delete();
                m_aligned = 0; m_cnt = 0;
            end else if (in_valid && in_ready) begin
                m_accept(in_data, in_sync, in_first);
            end
        end
    end

    always @(posedge clk) begin
        if (stall_mode) begin
            #2 out_ready = ($urandom % 4) != 0;
        end
    end

    task automatic send(input logic [7:0] d, input bit s, input bit f);
        if (stall_mode) begin
            int gap = $urandom % 3;
            repeat (gap) @(posedge clk);
            #2;
        end
        in_data = d; in_sync = s; in_first = f; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #2;
        in_valid = 1'b0; in_sync = 1'b0; in_first = 1'b0;
    endtask

    task automatic send_pkt(input bit f, input bit zero);
        send(8'h47, 1'b1, f);
        for (int i = 0; i < 187; i++) send(zero ? 8'h00 : 8'($urandom), 1'b0, 1'b0);
    endtask

    task automatic drain();
        repeat (6) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready, "R1", "in_ready after reset", in_ready, 1);

        // unaligned input is discarded
        cap.delete();
        send_pkt(1'b0, 1'b0);
        drain();
        check(cap.size() == 0, "R8", "outputs before alignment", cap.size(), 0);

        // nine zero-payload packets, only the first flagged
        cap.delete();
        for (int p = 0; p < 9; p++) send_pkt(p == 0, 1'b1);
        drain();
        check(cap.size() == 9 * 188, "R6", "byte count", cap.size(), 9 * 188);
        check(cap[0] == 8'hB8, "R2", "inverted sync", cap[0], 8'hB8);
        check(cap[1] == 8'h03, "R3", "first sequence byte", cap[1], 8'h03);
        check(cap[188] == 8'h47, "R4", "second packet sync", cap[188], 8'h47);
        check(cap[8 * 188] == 8'hB8, "R6", "ninth sync opens group", cap[8 * 188], 8'hB8);
        check(cap[8 * 188 + 1] == 8'h03, "R6", "sequence after 1503 bytes",
              cap[8 * 188 + 1], 8'h03);

        // out-of-place group flag on the third packet
        cap.delete();
        send_pkt(1'b0, 1'b1);
        send_pkt(1'b1, 1'b1);
        drain();
        check(cap[188] == 8'hB8 && cap[189] == 8'h03, "R7", "realign reseeds",
              {cap[188], cap[189]}, 16'hB803);

        // random payload with stalls on both sides
        stall_mode = 1'b1;
        for (int p = 0; p < 20; p++) send_pkt(p == 3, 1'b0);
        stall_mode = 1'b0;
        #1 out_ready = 1'b1;
        drain();

        // flush with a held output beat
        out_ready = 1'b0;
        send(8'h5A, 1'b0, 1'b0);
        @(negedge clk);
        check(out_valid, "R10", "beat held under backpressure", out_valid, 1);
        check(!in_ready, "R10", "in_ready under backpressure", in_ready, 0);
        @(posedge clk); #2 flush = 1'b1;
        @(posedge clk); #2 flush = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", "out_valid after flush", out_valid, 0);
        cap.delete();
        for (int i = 0; i < 20; i++) send(8'h11, 1'b0, 1'b0);
        send(8'h47, 1'b1, 1'b0);
        drain();
        check(cap.size() == 0, "R9", "unaligned after flush", cap.size(), 0);
        send_pkt(1'b1, 1'b1);
        drain();
        check(cap.size() == 188 && cap[1] == 8'h03, "R8", "resume on group flag",
              cap.size(), 188);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule